// File: doc/BRIEF.md
# Doorbell Command Mailbox

This block is a memory-mapped command mailbox. A host uses it to hand one command at a time to a device-side engine and to collect the result. The host first writes a 64-bit command word and any input data into a 2048-byte payload window. It then sets a doorbell bit and polls that bit until the engine clears it. When the bit is clear, the command word holds the output length and the status word holds the return code.

The register side accepts 4-byte and 8-byte accesses only, and each must be naturally aligned. Capability, status and background-status words are read-only. While a command is in flight, the command word, the payload and the control word are frozen against host writes, but every register can still be read.

The engine decodes a 16-bit opcode, formed as the command set shifted left by 8 OR'd with the opcode byte. It looks this value up in a small command table, checks the supplied length against the table, runs a fixed-latency handler and then writes back the results.

Top module: `mbx_doorbell_top`

## Requirements
- R1: An access is accepted only if it is aligned to its size: `size8_i`=1 means 8 bytes aligned to 8, and `size8_i`=0 means 4 bytes aligned to 4. A misaligned read returns zero and a misaligned write changes nothing.
- R2: The address map is as follows. Capability is at 0x000, with bits 4:0 = 11 (a payload of 2^11 bytes) and all other bits zero. Control is at 0x004, with the doorbell in bit 0. The command word is at 0x008 and the status word at 0x010. Background status is at 0x018 and always reads zero. The payload occupies 0x800-0xFFF. Unmapped addresses read zero. A 4-byte access carries its data in bits 31:0. Read data appears on `rdata_o` in the cycle after the request.
- R3: Host writes to capability, status and background status have no effect.
- R4: While the doorbell is clear, host writes to the command word and the payload are stored for the written bytes only.
- R5: Writing 1 to the doorbell bit sets it, and writing 0 has no effect. Only the engine clears it. The clear happens 3+HANDLER_LAT cycles after the setting write for an accepted command, and 3 cycles after it for a rejected one.
- R6: An opcode that is not in the table completes with return code 0x03 and output length 0, and the payload is left unchanged.
- R7: A supported opcode whose length field differs from its table input length completes with return code 0x16 and output length 0, and the payload is left unchanged.
- R8: On completion, command bits 15:0 become zero, bits 35:16 take the output length, and bits 63:36 keep their value. The status word holds the return code in bits 47:32 and zero in all other bits. Return code 0x00 means success.
- R9: While the doorbell is set, host writes to the command word, the payload and the control word are ignored. Status reads return the previous result.
- R10: The table holds three opcodes. Opcode 0x0100 takes input length 0, writes payload word 0 = 0xC0DE5EED00000001 and word 1 = 2048, and has output length 16. Opcode 0x0101 takes input length 8, leaves the payload unchanged, and its output length equals the input length. Opcode 0x0201 takes input length 16, inverts payload words 0 and 1, and has output length 16.
- R11: The output length written back never exceeds 2048.
- R12: After reset, the doorbell, command word, status word and payload are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size8_i | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, registered |

## Verification
Commands are run with three patterns: a matching length, a mismatched length (including the largest 20-bit value), and an opcode that is not in the table. Together these separate the success path, the length-check path and the table-miss path, through the return code, the output length and the payload contents. The doorbell is polled on every cycle and compared against the predicted clear cycle, which tells the short reject latency apart from the full handler latency. One command is also run with command, payload and control writes issued during the busy window, which shows whether the freeze holds.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned OP_W  = 16;
  localparam int unsigned LEN_W = 20;
  localparam int unsigned RC_W  = 16;

  typedef enum logic [1:0] {H_IDENT, H_ECHO, H_INVERT} handler_e;
  typedef enum logic [1:0] {ST_IDLE, ST_DECODE, ST_EXEC, ST_DONE} eng_state_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [LEN_W-1:0] in_len;
    handler_e         kind;
  } cmd_entry_t;

  localparam int unsigned N_CMDS = 3;

  localparam logic [RC_W-1:0] RC_OK     = 16'h0000;
  localparam logic [RC_W-1:0] RC_UNSUP  = 16'h0003;
  localparam logic [RC_W-1:0] RC_BADLEN = 16'h0016;

  localparam logic [63:0] IDENT_W0 = 64'hC0DE_5EED_0000_0001;

  function automatic cmd_entry_t cmd_entry(input int unsigned idx);
    cmd_entry_t e;
    case (idx)
      0:       e = '{op: 16'h0100, in_len: 20'd0,  kind: H_IDENT};
      1:       e = '{op: 16'h0101, in_len: 20'd8,  kind: H_ECHO};
      2:       e = '{op: 16'h0201, in_len: 20'd16, kind: H_INVERT};
      default: e = '{op: 16'hFFFF, in_len: '0,     kind: H_ECHO};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/mbx_cmd_table.sv
module mbx_cmd_table
  import mbx_pkg::*;
#(
  parameter int unsigned N = N_CMDS
) (
  input  logic [OP_W-1:0]  op_i,
  output logic             hit_o,
  output logic [LEN_W-1:0] in_len_o,
  output handler_e         kind_o
);

  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_match
    assign match[g] = (cmd_entry(g).op == op_i);
  end

  always_comb begin
    hit_o    = 1'b0;
    in_len_o = '0;
    kind_o   = H_ECHO;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        hit_o    = 1'b1;
        in_len_o = cmd_entry(i).in_len;
        kind_o   = cmd_entry(i).kind;
      end
    end
  end

endmodule

// File: rtl/mbx_payload_store.sv
module mbx_payload_store #(
  parameter int unsigned WORDS = 256,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       host_we_i,
  input  logic [IDX_W-1:0] host_idx_i,
  input  logic [63:0]      host_wdata_i,
  output logic [63:0]      host_rdata_o,
  input  logic             eng_we_i,
  input  logic [IDX_W-1:0] eng_widx_i,
  input  logic [63:0]      eng_wdata_i,
  input  logic [IDX_W-1:0] eng_ridx_i,
  output logic [63:0]      eng_rdata_o
);

  logic [63:0] mem [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (eng_we_i) begin
      mem[eng_widx_i] <= eng_wdata_i;
    end else begin
      if (host_we_i[0]) mem[host_idx_i][31:0]  <= host_wdata_i[31:0];
      if (host_we_i[1]) mem[host_idx_i][63:32] <= host_wdata_i[63:32];
    end
  end

  assign host_rdata_o = mem[host_idx_i];
  assign eng_rdata_o  = mem[eng_ridx_i];

endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
  import mbx_pkg::*;
#(
  parameter int unsigned HANDLER_LAT   = 4,
  parameter int unsigned PAYLOAD_BYTES = 2048,
  parameter int unsigned IDX_W         = 8,
  localparam int unsigned CNT_W = $clog2(HANDLER_LAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             db_i,
  input  logic [63:0]      cmd_i,
  output logic [IDX_W-1:0] pl_ridx_o,
  input  logic [63:0]      pl_rdata_i,
  output logic             pl_we_o,
  output logic [IDX_W-1:0] pl_widx_o,
  output logic [63:0]      pl_wdata_o,
  output logic             done_o,
  output logic [63:0]      cmd_new_o,
  output logic [63:0]      sts_new_o
);

  eng_state_e       state_q;
  logic [OP_W-1:0]  op_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] olen_q;
  logic [RC_W-1:0]  rc_q;
  handler_e         kind_q;
  logic [CNT_W-1:0] cnt_q;

  logic             tbl_hit;
  logic [LEN_W-1:0] tbl_in_len;
  handler_e         tbl_kind;

  mbx_cmd_table u_table (
    .op_i     (op_q),
    .hit_o    (tbl_hit),
    .in_len_o (tbl_in_len),
    .kind_o   (tbl_kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      len_q   <= '0;
      olen_q  <= '0;
      rc_q    <= '0;
      kind_q  <= H_ECHO;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (db_i) begin
          op_q    <= cmd_i[15:0];
          len_q   <= cmd_i[35:16];
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          kind_q <= tbl_kind;
          cnt_q  <= '0;
          if (!tbl_hit) begin
            rc_q    <= RC_UNSUP;
            olen_q  <= '0;
            state_q <= ST_DONE;
          end else if (len_q != tbl_in_len) begin
            rc_q    <= RC_BADLEN;
            olen_q  <= '0;
            state_q <= ST_DONE;
          end else begin
            rc_q    <= RC_OK;
            olen_q  <= (tbl_kind == H_ECHO) ? len_q : LEN_W'(16);
            state_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (cnt_q == CNT_W'(HANDLER_LAT - 1)) state_q <= ST_DONE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // handlers touch payload words 0 and 1 during the first two exec cycles
  always_comb begin
    pl_ridx_o  = IDX_W'(cnt_q);
    pl_widx_o  = IDX_W'(cnt_q);
    pl_we_o    = (state_q == ST_EXEC) && (kind_q != H_ECHO) && (cnt_q < CNT_W'(2));
    pl_wdata_o = ~pl_rdata_i;
    if (kind_q == H_IDENT) pl_wdata_o = (cnt_q == '0) ? IDENT_W0 : 64'(PAYLOAD_BYTES);
  end

  assign done_o    = (state_q == ST_DONE);
  assign cmd_new_o = {cmd_i[63:36], olen_q, 16'h0000};
  assign sts_new_o = {16'h0000, rc_q, 32'h0000_0000};

endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top #(
  parameter int unsigned PAYLOAD_BYTES = 2048,
  parameter int unsigned HANDLER_LAT   = 4,
  localparam int unsigned PL_SHIFT = $clog2(PAYLOAD_BYTES),
  localparam int unsigned ADDR_W   = PL_SHIFT + 1,
  localparam int unsigned PL_WORDS = PAYLOAD_BYTES / 8,
  localparam int unsigned PL_IDX_W = $clog2(PL_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              size8_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o
);

  logic        db_q;
  logic [63:0] cmd_q;
  logic [63:0] sts_q;
  logic [63:0] rdata_q;

  logic                eng_done;
  logic [63:0]         cmd_new, sts_new;
  logic                eng_we;
  logic [PL_IDX_W-1:0] eng_widx, eng_ridx;
  logic [63:0]         eng_wdata, eng_rdata;
  logic [63:0]         pl_rdata;

  logic        aligned, wr, rd, in_pl, in_regs;
  logic [1:0]  reg_idx, lane_en;
  logic [63:0] wword, rword;

  assign aligned = size8_i ? (addr_i[2:0] == 3'b000) : (addr_i[1:0] == 2'b00);
  assign wr      = req_i && we_i && aligned;
  assign rd      = req_i && !we_i;
  assign in_pl   = addr_i[ADDR_W-1];
  assign in_regs = !in_pl && (addr_i[ADDR_W-2:5] == '0);
  assign reg_idx = addr_i[4:3];
  assign lane_en = size8_i ? 2'b11 : (addr_i[2] ? 2'b10 : 2'b01);
  assign wword   = size8_i ? wdata_i : {wdata_i[31:0], wdata_i[31:0]};

  logic [1:0] cmd_we, pl_we;
  logic       db_set;
  assign cmd_we = {2{wr && in_regs && reg_idx == 2'd1 && !db_q}} & lane_en;
  assign pl_we  = {2{wr && in_pl && !db_q}} & lane_en;
  assign db_set = wr && in_regs && reg_idx == 2'd0 && lane_en[1] && !db_q && wword[32];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q  <= 1'b0;
      cmd_q <= '0;
      sts_q <= '0;
    end else if (eng_done) begin
      db_q  <= 1'b0;
      cmd_q <= cmd_new;
      sts_q <= sts_new;
    end else begin
      if (db_set)    db_q          <= 1'b1;
      if (cmd_we[0]) cmd_q[31:0]   <= wword[31:0];
      if (cmd_we[1]) cmd_q[63:32]  <= wword[63:32];
    end
  end

  mbx_payload_store #(.WORDS(PL_WORDS)) u_payload (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (pl_we),
    .host_idx_i   (addr_i[PL_SHIFT-1:3]),
    .host_wdata_i (wword),
    .host_rdata_o (pl_rdata),
    .eng_we_i     (eng_we),
    .eng_widx_i   (eng_widx),
    .eng_wdata_i  (eng_wdata),
    .eng_ridx_i   (eng_ridx),
    .eng_rdata_o  (eng_rdata)
  );

  mbx_engine #(
    .HANDLER_LAT   (HANDLER_LAT),
    .PAYLOAD_BYTES (PAYLOAD_BYTES),
    .IDX_W         (PL_IDX_W)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .db_i       (db_q),
    .cmd_i      (cmd_q),
    .pl_ridx_o  (eng_ridx),
    .pl_rdata_i (eng_rdata),
    .pl_we_o    (eng_we),
    .pl_widx_o  (eng_widx),
    .pl_wdata_o (eng_wdata),
    .done_o     (eng_done),
    .cmd_new_o  (cmd_new),
    .sts_new_o  (sts_new)
  );

  always_comb begin
    rword = '0;
    if (in_pl) rword = pl_rdata;
    else if (in_regs) begin
      case (reg_idx)
        2'd0:    rword = {31'b0, db_q, 32'(PL_SHIFT)};
        2'd1:    rword = cmd_q;
        2'd2:    rword = sts_q;
        default: rword = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) begin
      if (!aligned)     rdata_q <= '0;
      else if (size8_i) rdata_q <= rword;
      else              rdata_q <= {32'b0, addr_i[2] ? rword[63:32] : rword[31:0]};
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
  parameter int unsigned PAYLOAD_BYTES = 2048
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic        size8_i,
  input logic [2:0]  addr_lo_i,
  input logic [63:0] rdata_i,
  input logic        db_i,
  input logic        done_i,
  input logic [63:0] cmd_i,
  input logic [63:0] sts_i
);

  logic mis_rd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mis_rd_q <= 1'b0;
    else mis_rd_q <= req_i && !we_i && (size8_i ? (addr_lo_i != 3'b000) : (addr_lo_i[1:0] != 2'b00));
  end

  AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_rd_q |-> rdata_i == 64'h0); // R1

  AST_STATUS_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(done_i) |-> $stable(sts_i)); // R3

  AST_DB_FALL_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(db_i) |-> $past(done_i)); // R5

  AST_DONE_NEEDS_DB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> db_i); // R5

  AST_CMD_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_i && $past(db_i)) |-> $stable(cmd_i)); // R9

  AST_OPCODE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_i) |-> cmd_i[15:0] == 16'h0 && sts_i[31:0] == 32'h0 && sts_i[63:48] == 16'h0); // R8

  AST_OUTLEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_i) |-> cmd_i[35:16] <= 20'(PAYLOAD_BYTES)); // R11

endmodule

bind mbx_doorbell_top mbx_doorbell_chk #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .size8_i   (size8_i),
  .addr_lo_i (addr_i[2:0]),
  .rdata_i   (rdata_o),
  .db_i      (db_q),
  .done_i    (eng_done),
  .cmd_i     (cmd_q),
  .sts_i     (sts_q)
);

// File: tb/mbx_doorbell_top_tb_top.sv
`timescale 1ns/1ps
module mbx_doorbell_top_tb_top;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, size8 = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;

  // behavioural model state
  logic [63:0] mpl [256];
  logic [63:0] mcmd = '0, msts = '0;
  logic        mdb = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mbx_doorbell_top #(.PAYLOAD_BYTES(2048), .HANDLER_LAT(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size8_i(size8),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  function automatic bit misal(input logic [11:0] a, input logic s8);
    return s8 ? (a[2:0] != 0) : (a[1:0] != 0);
  endfunction

  function automatic logic [63:0] mread(input logic [11:0] a, input logic s8);
    logic [63:0] w = '0;
    if (misal(a, s8)) return '0;
    if (a[11]) w = mpl[a[10:3]];
    else if (a[10:5] == 0) begin
      case (a[4:3])
        2'd0: w = {31'b0, mdb, 32'd11};
        2'd1: w = mcmd;
        2'd2: w = msts;
        default: w = '0;
      endcase
    end
    if (s8) return w;
    return {32'b0, a[2] ? w[63:32] : w[31:0]};
  endfunction

  function automatic void mwrite(input logic [11:0] a, input logic s8, input logic [63:0] d);
    logic [63:0] ww;
    logic [1:0] ln;
    if (misal(a, s8)) return;
    ww = s8 ? d : {d[31:0], d[31:0]};
    ln = s8 ? 2'b11 : (a[2] ? 2'b10 : 2'b01);
    if (mdb) return;
    if (a[11]) begin
      if (ln[0]) mpl[a[10:3]][31:0]  = ww[31:0];
      if (ln[1]) mpl[a[10:3]][63:32] = ww[63:32];
    end else if (a[10:5] == 0) begin
      if (a[4:3] == 2'd1) begin
        if (ln[0]) mcmd[31:0]  = ww[31:0];
        if (ln[1]) mcmd[63:32] = ww[63:32];
      end else if (a[4:3] == 2'd0 && ln[1] && ww[32]) mdb = 1'b1;
    end
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic s8, input logic [63:0] d);
    req = 1; we = 1; size8 = s8; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 0; we = 0;
    mwrite(a, s8, d);
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic s8, output logic [63:0] d);
    req = 1; we = 0; size8 = s8; addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata; req = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic s8);
    logic [63:0] d;
    bus_rd(a, s8, d);
    chk(tag, d, mread(a, s8));
  endtask

  task automatic run_cmd(input logic [7:0] cset, input logic [7:0] op,
                         input logic [19:0] len, input bit poke);
    logic [63:0] d;
    logic [15:0] op16, rc;
    logic [19:0] olen;
    int in_len, lim, edge_id;
    bit sup;
    bus_wr(12'h008, 1'b1, {28'hA5A5A5A, len, cset, op});
    op16 = {cset, op};
    sup = 1'b1;
    case (op16)
      16'h0100: in_len = 0;
      16'h0101: in_len = 8;
      16'h0201: in_len = 16;
      default: begin in_len = 0; sup = 1'b0; end
    endcase
    lim = (sup && len == 20'(in_len)) ? 3 + LAT : 3;
    bus_wr(12'h004, 1'b0, 64'h1);
    edge_id = cyc;
    if (poke) begin
      bus_wr(12'h008, 1'b1, 64'hDEAD_BEEF_0000_0000);
      bus_wr(12'h800, 1'b1, 64'h1111_2222_3333_4444);
      bus_wr(12'h004, 1'b0, 64'h0);
      bus_rd(12'h010, 1'b1, d);
      chk("R9 status read while busy", d, msts);
    end
    for (int k = 0; k < 40; k++) begin
      bus_rd(12'h004, 1'b0, d);
      chk("R5 doorbell per-cycle", {63'b0, d[32'd0]}, {63'b0, (cyc - edge_id) <= lim});
      if (!d[0]) break;
    end
    // expected completion
    if (!sup) begin rc = 16'h0003; olen = 0; end
    else if (len != 20'(in_len)) begin rc = 16'h0016; olen = 0; end
    else begin
      rc = 16'h0000;
      case (op16)
        16'h0100: begin mpl[0] = 64'hC0DE_5EED_0000_0001; mpl[1] = 64'd2048; olen = 16; end
        16'h0101: olen = len;
        default:  begin mpl[0] = ~mpl[0]; mpl[1] = ~mpl[1]; olen = 16; end
      endcase
    end
    mcmd = {mcmd[63:36], olen, 16'h0};
    msts = {16'h0, rc, 32'h0};
    mdb = 1'b0;
    rd_chk("R8 command writeback", 12'h008, 1'b1);
    rd_chk("R6 R7 R10 status code", 12'h010, 1'b1);
    rd_chk("R10 payload word0", 12'h800, 1'b1);
    rd_chk("R10 payload word1", 12'h808, 1'b1);
    rd_chk("R11 length in range", 12'h00C, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mpl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 / R2 reset state and map
    rd_chk("R12 ctrl+cap", 12'h000, 1'b1);
    rd_chk("R2 cap 4B", 12'h000, 1'b0);
    rd_chk("R12 command", 12'h008, 1'b1);
    rd_chk("R12 status", 12'h010, 1'b1);
    rd_chk("R2 bg status", 12'h018, 1'b1);
    rd_chk("R12 payload first", 12'h800, 1'b1);
    rd_chk("R12 payload last", 12'hFF8, 1'b1);
    rd_chk("R2 unmapped", 12'h020, 1'b1);

    // R4 stores
    bus_wr(12'h008, 1'b1, 64'h0123_4567_89AB_CDEF);
    rd_chk("R4 command 8B", 12'h008, 1'b1);
    bus_wr(12'h00C, 1'b0, 64'h0000_0000_1234_5678);
    rd_chk("R4 command hi 4B", 12'h00C, 1'b0);
    rd_chk("R4 command lo kept", 12'h008, 1'b1);
    bus_wr(12'h808, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD);
    bus_wr(12'h80C, 1'b0, 64'h0000_0000_5555_6666);
    rd_chk("R4 payload lane", 12'h808, 1'b1);
    bus_wr(12'hFF8, 1'b1, 64'hFEED_FACE_0BAD_F00D);
    rd_chk("R4 payload top", 12'hFF8, 1'b1);

    // R1 alignment
    bus_wr(12'h804, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R1 misaligned write dropped lo", 12'h800, 1'b1);
    rd_chk("R1 misaligned write dropped hi", 12'h808, 1'b1);
    bus_wr(12'h00A, 1'b0, 64'hFFFF_FFFF);
    rd_chk("R1 misaligned 4B write", 12'h008, 1'b1);
    rd_chk("R1 misaligned 8B read", 12'h00C, 1'b1);
    rd_chk("R1 misaligned 4B read", 12'h802, 1'b0);

    // R3 read-only words
    bus_wr(12'h010, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R3 status RO", 12'h010, 1'b1);
    bus_wr(12'h018, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R3 bg status RO", 12'h018, 1'b1);
    bus_wr(12'h000, 1'b0, 64'hFFFF_FFFF);
    rd_chk("R3 capability RO", 12'h000, 1'b0);

    // R5 writing zero
    bus_wr(12'h004, 1'b0, 64'h0);
    rd_chk("R5 doorbell stays clear", 12'h004, 1'b0);

    // commands
    bus_wr(12'h800, 1'b1, 64'h0F0F_1234_5678_9ABC);
    bus_wr(12'h808, 1'b1, 64'h8000_0000_0000_0001);
    run_cmd(8'h01, 8'h01, 20'd8, 1'b0);      // R10 echo
    run_cmd(8'h02, 8'h01, 20'd16, 1'b1);     // R10 invert, R9 busy pokes
    run_cmd(8'h03, 8'h05, 20'd16, 1'b0);     // R6 unsupported
    run_cmd(8'h01, 8'h01, 20'hFFFFF, 1'b0);  // R7 max length
    run_cmd(8'h02, 8'h01, 20'd8, 1'b0);      // R7 short length
    run_cmd(8'h00, 8'h00, 20'd0, 1'b0);      // R6 zero opcode
    run_cmd(8'h01, 8'h00, 20'd0, 1'b0);      // R10 identify
    run_cmd(8'h02, 8'h01, 20'd16, 1'b0);     // R10 invert of identify data

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule